// File: doc/BRIEF.md
# Calendar shadow register synchronizer

This block gives a fast peripheral bus a coherent view of a slow real-time-clock calendar. The calendar keeps three live counters: subsecond, time of day and date. Every two RTC clock periods, the RTC side latches all three counters into a hold set and flips a toggle. The bus side passes that toggle through two flip-flops. When it sees the toggle change, it copies the hold set into three bus-side shadow registers and raises a "synchronized" flag. Software may clear that flag. It clears it after a wakeup, or between reads that come closer together than two RTC periods, and then waits for the flag to set again.

A completed shadow-mode read of the time or subsecond register closes a lock. While the lock is held no copy is taken, so the date read that follows returns a value from the same snapshot. The date read opens the lock again. While the low-power input is high no copies are taken. With the bypass input high, calendar reads return the live counters directly and take one added wait cycle. The RTC-side snapshot logic is reset only by the power-on reset. The system reset clears the shadows, the flag, the lock and the bus state machine.

The design uses four state machines:
- Snapshot phase `PH_WAIT`/`PH_SNAP`. The machine alternates between the two every RTC clock, and latching happens on leaving `PH_SNAP`.
- Crossing start-up `SY_FILL`→`SY_SETTLE`→`SY_ARM`→`SY_RUN`. The machine steps through these once after reset, priming the edge detector. It stays in `SY_RUN` afterwards.
- Lock `LK_OPEN`→`LK_HELD`. The lock closes on a time or subsecond shadow read and returns to `LK_OPEN` on a date read.
- Bus `BP_IDLE`→`BP_BYP_WAIT`. The bus machine moves to `BP_BYP_WAIT` on the first access cycle of a bypass calendar read and returns to `BP_IDLE` on the next cycle.

Top module: `cal_shadow_sync`

## Requirements
- R1: After a system reset, the status register bit 0 (flag) reads 0. The time, date and subsecond registers read 0 until the first copy after reset.
- R2: While low power is low and the lock is open, a copy is taken once every two RTC clock periods. The flag sets within two RTC periods plus six bus clocks. All three shadows come from the same snapshot, and that snapshot is at most three counter steps old.
- R3: A completed write with data bit 0 equal to 0 at address 0xC clears the flag. A write with bit 0 equal to 1 leaves the flag unchanged.
- R4: A completed shadow-mode read of time (0x0) or subsecond (0x8) closes the lock. While the lock is held no copy is taken and the flag does not set. The following date read (0x4) returns the date of the same snapshot.
- R5: A completed read of date opens the lock, and the next copy then lands with newer values.
- R6: While low power is high no copy is taken: the shadows hold their values and the flag does not set. After low power falls, the flag sets again with a fresh copy.
- R7: With bypass high, reads of 0x0, 0x4 and 0x8 return the live counters, and those reads do not close the lock.
- R8: With bypass high, a calendar read holds pready low for exactly one access cycle. Status reads, and every read with bypass low, complete in their first access cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| sys_rst_n | input | 1 | System reset, active low: clears shadows, flag, lock and bus state |
| rtc_clk | input | 1 | Slow calendar clock |
| por_n | input | 1 | Power-on reset, active low: clears RTC-side snapshot logic |
| live_ss | input | 16 | Live subsecond counter (RTC domain) |
| live_tm | input | 24 | Live time counter (RTC domain) |
| live_dt | input | 24 | Live date counter (RTC domain) |
| bypass | input | 1 | 1: calendar reads return live counters |
| lowpwr | input | 1 | 1: low-power mode, no shadow copies |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1: write, 0: read |
| paddr | input | 4 | Byte address: 0x0 time, 0x4 date, 0x8 subsecond, 0xC status |
| pwdata | input | 32 | Write data; bit 0 used at 0xC |
| prdata | output | 32 | Read data, zero-extended |
| pready | output | 1 | Transfer completes in a cycle where psel, penable and pready are high |

## Verification
The hardest case to reach is a held lock with the calendar still running underneath it. A time read has to leave the date frozen for several copies, and the snapshot has to be observable at the ports. The stimulus reads time and then clears the flag. It waits about six RTC periods, so that the live counters advance well past the read value. It then checks that the flag stayed clear and that the date still matches the earlier time through the known date relation. Low power is held high around the reset and flag-clear checks, so that no copy can race the reads.

// File: rtl/cal_shadow_pkg.sv
package cal_shadow_pkg;

    localparam int ADDR_W  = 4;
    localparam int SEL_LSB = 2;
    localparam int FLAG_BIT = 0;

    typedef enum logic [1:0] {
        SEL_TIME   = 2'd0,
        SEL_DATE   = 2'd1,
        SEL_SUBSEC = 2'd2,
        SEL_STATUS = 2'd3
    } reg_sel_e;

    typedef enum logic {
        PH_WAIT = 1'b0,
        PH_SNAP = 1'b1
    } snap_ph_e;

    typedef enum logic [1:0] {
        SY_FILL   = 2'd0,
        SY_SETTLE = 2'd1,
        SY_ARM    = 2'd2,
        SY_RUN    = 2'd3
    } sync_st_e;

    typedef enum logic {
        LK_OPEN = 1'b0,
        LK_HELD = 1'b1
    } lock_st_e;

    typedef enum logic {
        BP_IDLE     = 1'b0,
        BP_BYP_WAIT = 1'b1
    } bus_st_e;

endpackage

// File: rtl/cal_rtc_snap.sv
module cal_rtc_snap
    import cal_shadow_pkg::*;
#(
    parameter int SS_W = 16,
    parameter int TM_W = 24,
    parameter int DT_W = 24
) (
    input  logic            rtc_clk,
    input  logic            por_n,
    input  logic [SS_W-1:0] live_ss,
    input  logic [TM_W-1:0] live_tm,
    input  logic [DT_W-1:0] live_dt,
    output logic [SS_W-1:0] hold_ss,
    output logic [TM_W-1:0] hold_tm,
    output logic [DT_W-1:0] hold_dt,
    output logic            snap_tgl
);

    snap_ph_e ph_q, ph_d;

    // state register
    always_ff @(posedge rtc_clk or negedge por_n) begin
        if (!por_n) begin
            ph_q <= PH_WAIT;
        end else begin
            ph_q <= ph_d;
        end
    end

    // next state: alternate every RTC clock, giving one snapshot per two periods
    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_WAIT: ph_d = PH_SNAP;
            PH_SNAP: ph_d = PH_WAIT;
        endcase
    end

    // outputs: latch the counters together and announce them with a toggle
    always_ff @(posedge rtc_clk or negedge por_n) begin
        if (!por_n) begin
            hold_ss  <= '0;
            hold_tm  <= '0;
            hold_dt  <= '0;
            snap_tgl <= 1'b0;
        end else if (ph_q == PH_SNAP) begin
            hold_ss  <= live_ss;
            hold_tm  <= live_tm;
            hold_dt  <= live_dt;
            snap_tgl <= ~snap_tgl;
        end
    end

    AST_TGL_SPACED: assert property (@(posedge rtc_clk) disable iff (!por_n)
        (snap_tgl != $past(snap_tgl)) |=> $stable(snap_tgl)); // R2

    AST_HOLD_ON_TGL: assert property (@(posedge rtc_clk) disable iff (!por_n)
        $stable(snap_tgl) |-> $stable(hold_tm)); // R2

endmodule

// File: rtl/cal_cdc_sync.sv
module cal_cdc_sync
    import cal_shadow_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic pclk,
    input  logic sys_rst_n,
    input  logic tgl_async,
    output logic copy_go
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;
    logic              sync_out;
    sync_st_e          st_q, st_d;

    assign sync_out = sync_q[STAGES-1];

    // synchronizer chain
    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge pclk or negedge sys_rst_n) begin
                    if (!sys_rst_n) sync_q[0] <= 1'b0;
                    else            sync_q[0] <= tgl_async;
                end
            end else begin : g_next
                always_ff @(posedge pclk or negedge sys_rst_n) begin
                    if (!sys_rst_n) sync_q[i] <= 1'b0;
                    else            sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    // state register
    always_ff @(posedge pclk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            st_q   <= SY_FILL;
            last_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            last_q <= sync_out;
        end
    end

    // start-up sequence lets the chain fill before edges count
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SY_FILL:   st_d = SY_SETTLE;
            SY_SETTLE: st_d = SY_ARM;
            SY_ARM:    st_d = SY_RUN;
            SY_RUN:    st_d = SY_RUN;
        endcase
    end

    // outputs
    always_comb begin
        copy_go = (st_q == SY_RUN) && (sync_out != last_q);
    end

    AST_ONE_PULSE: assert property (@(posedge pclk) disable iff (!sys_rst_n)
        copy_go |=> !copy_go); // R2

endmodule

// File: rtl/cal_shadow_bank.sv
module cal_shadow_bank
    import cal_shadow_pkg::*;
#(
    parameter int SS_W = 16,
    parameter int TM_W = 24,
    parameter int DT_W = 24
) (
    input  logic            pclk,
    input  logic            sys_rst_n,
    input  logic            copy_go,
    input  logic            lowpwr,
    input  logic [SS_W-1:0] hold_ss,
    input  logic [TM_W-1:0] hold_tm,
    input  logic [DT_W-1:0] hold_dt,
    input  logic            lock_arm,
    input  logic            lock_release,
    input  logic            flag_clr,
    output logic [SS_W-1:0] sh_ss,
    output logic [TM_W-1:0] sh_tm,
    output logic [DT_W-1:0] sh_dt,
    output logic            flag
);

    lock_st_e lk_q, lk_d;
    logic     load;

    // state register
    always_ff @(posedge pclk or negedge sys_rst_n) begin
        if (!sys_rst_n) lk_q <= LK_OPEN;
        else            lk_q <= lk_d;
    end

    // lock transitions
    always_comb begin
        lk_d = lk_q;
        unique case (lk_q)
            LK_OPEN: if (lock_arm)     lk_d = LK_HELD;
            LK_HELD: if (lock_release) lk_d = LK_OPEN;
        endcase
    end

    // a copy lands only with the lock open and no lock closing this cycle
    always_comb begin
        load = copy_go && !lowpwr && (lk_q == LK_OPEN) && !lock_arm;
    end

    // outputs: shadows and flag
    always_ff @(posedge pclk or negedge sys_rst_n) begin
        if (!sys_rst_n) begin
            sh_ss <= '0;
            sh_tm <= '0;
            sh_dt <= '0;
            flag  <= 1'b0;
        end else begin
            if (load) begin
                sh_ss <= hold_ss;
                sh_tm <= hold_tm;
                sh_dt <= hold_dt;
            end
            if (load)          flag <= 1'b1;
            else if (flag_clr) flag <= 1'b0;
        end
    end

    AST_DATE_FROZEN: assert property (@(posedge pclk) disable iff (!sys_rst_n)
        (lk_q == LK_HELD) |=> $stable(sh_dt)); // R4

    AST_LP_NO_LOAD: assert property (@(posedge pclk) disable iff (!sys_rst_n)
        lowpwr |=> $stable(sh_tm)); // R6

    AST_FLAG_RISE_COPY: assert property (@(posedge pclk) disable iff (!sys_rst_n)
        $rose(flag) |-> $past(copy_go)); // R2

    AST_FLAG_FALL_WRITE: assert property (@(posedge pclk) disable iff (!sys_rst_n)
        $fell(flag) |-> $past(flag_clr)); // R3

endmodule

// File: rtl/cal_bus_port.sv
module cal_bus_port
    import cal_shadow_pkg::*;
#(
    parameter int SS_W   = 16,
    parameter int TM_W   = 24,
    parameter int DT_W   = 24,
    parameter int DATA_W = 32
) (
    input  logic              pclk,
    input  logic              sys_rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic              bypass,
    input  logic [SS_W-1:0]   sh_ss,
    input  logic [TM_W-1:0]   sh_tm,
    input  logic [DT_W-1:0]   sh_dt,
    input  logic [SS_W-1:0]   live_ss,
    input  logic [TM_W-1:0]   live_tm,
    input  logic [DT_W-1:0]   live_dt,
    input  logic              flag,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              lock_arm,
    output logic              lock_release,
    output logic              flag_clr
);

    bus_st_e  st_q, st_d;
    reg_sel_e sel;
    logic     access;
    logic     is_cal;
    logic     done;
    logic     unused_bits;

    assign sel         = reg_sel_e'(paddr[SEL_LSB +: 2]);
    assign access      = psel && penable;
    assign is_cal      = (sel != SEL_STATUS);
    assign unused_bits = ^{pwdata[DATA_W-1:1], paddr[SEL_LSB-1:0]};

    // state register
    always_ff @(posedge pclk or negedge sys_rst_n) begin
        if (!sys_rst_n) st_q <= BP_IDLE;
        else            st_q <= st_d;
    end

    // next state: bypass calendar reads spend one cycle in BP_BYP_WAIT
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BP_IDLE:     if (access && !pwrite && bypass && is_cal) st_d = BP_BYP_WAIT;
            BP_BYP_WAIT: st_d = BP_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        pready = 1'b1;
        unique case (st_q)
            BP_IDLE:     if (access && !pwrite && bypass && is_cal) pready = 1'b0;
            BP_BYP_WAIT: pready = 1'b1;
        endcase
        done         = access && pready;
        lock_arm     = done && !pwrite && !bypass && ((sel == SEL_TIME) || (sel == SEL_SUBSEC));
        lock_release = done && !pwrite && (sel == SEL_DATE);
        flag_clr     = done && pwrite && (sel == SEL_STATUS) && !pwdata[FLAG_BIT];
    end

    always_comb begin
        prdata = '0;
        unique case (sel)
            SEL_TIME:   prdata = bypass ? DATA_W'(live_tm) : DATA_W'(sh_tm);
            SEL_DATE:   prdata = bypass ? DATA_W'(live_dt) : DATA_W'(sh_dt);
            SEL_SUBSEC: prdata = bypass ? DATA_W'(live_ss) : DATA_W'(sh_ss);
            SEL_STATUS: prdata = DATA_W'(flag);
        endcase
    end

    AST_BYP_HAS_WAIT: assert property (@(posedge pclk) disable iff (!sys_rst_n)
        (access && pready && !pwrite && bypass && is_cal) |-> $past(access)); // R8

    AST_WAIT_COMPLETES: assert property (@(posedge pclk) disable iff (!sys_rst_n)
        (st_q == BP_BYP_WAIT) |-> (access && pready)); // R8

    AST_NO_LOCK_BYPASS: assert property (@(posedge pclk) disable iff (!sys_rst_n)
        bypass |-> !lock_arm); // R7

endmodule

// File: rtl/cal_shadow_sync.sv
module cal_shadow_sync
    import cal_shadow_pkg::*;
#(
    parameter int SS_W   = 16,
    parameter int TM_W   = 24,
    parameter int DT_W   = 24,
    parameter int DATA_W = 32,
    parameter int STAGES = 2
) (
    input  logic              pclk,
    input  logic              sys_rst_n,
    input  logic              rtc_clk,
    input  logic              por_n,
    input  logic [SS_W-1:0]   live_ss,
    input  logic [TM_W-1:0]   live_tm,
    input  logic [DT_W-1:0]   live_dt,
    input  logic              bypass,
    input  logic              lowpwr,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready
);

    logic [SS_W-1:0] hold_ss, sh_ss;
    logic [TM_W-1:0] hold_tm, sh_tm;
    logic [DT_W-1:0] hold_dt, sh_dt;
    logic            snap_tgl;
    logic            copy_go;
    logic            flag;
    logic            lock_arm, lock_release, flag_clr;

    cal_rtc_snap #(.SS_W(SS_W), .TM_W(TM_W), .DT_W(DT_W)) u_snap (
        .rtc_clk  (rtc_clk),
        .por_n    (por_n),
        .live_ss  (live_ss),
        .live_tm  (live_tm),
        .live_dt  (live_dt),
        .hold_ss  (hold_ss),
        .hold_tm  (hold_tm),
        .hold_dt  (hold_dt),
        .snap_tgl (snap_tgl)
    );

    cal_cdc_sync #(.STAGES(STAGES)) u_sync (
        .pclk      (pclk),
        .sys_rst_n (sys_rst_n),
        .tgl_async (snap_tgl),
        .copy_go   (copy_go)
    );

    cal_shadow_bank #(.SS_W(SS_W), .TM_W(TM_W), .DT_W(DT_W)) u_bank (
        .pclk         (pclk),
        .sys_rst_n    (sys_rst_n),
        .copy_go      (copy_go),
        .lowpwr       (lowpwr),
        .hold_ss      (hold_ss),
        .hold_tm      (hold_tm),
        .hold_dt      (hold_dt),
        .lock_arm     (lock_arm),
        .lock_release (lock_release),
        .flag_clr     (flag_clr),
        .sh_ss        (sh_ss),
        .sh_tm        (sh_tm),
        .sh_dt        (sh_dt),
        .flag         (flag)
    );

    cal_bus_port #(.SS_W(SS_W), .TM_W(TM_W), .DT_W(DT_W), .DATA_W(DATA_W)) u_bus (
        .pclk         (pclk),
        .sys_rst_n    (sys_rst_n),
        .psel         (psel),
        .penable      (penable),
        .pwrite       (pwrite),
        .paddr        (paddr),
        .pwdata       (pwdata),
        .bypass       (bypass),
        .sh_ss        (sh_ss),
        .sh_tm        (sh_tm),
        .sh_dt        (sh_dt),
        .live_ss      (live_ss),
        .live_tm      (live_tm),
        .live_dt      (live_dt),
        .flag         (flag),
        .prdata       (prdata),
        .pready       (pready),
        .lock_arm     (lock_arm),
        .lock_release (lock_release),
        .flag_clr     (flag_clr)
    );

endmodule

// File: tb/cal_shadow_sync_test.sv
module cal_shadow_sync_test;

    localparam int PCLK_PERIOD = 10;
    localparam int RTC_HALF    = 85;
    localparam int WDOG_NS     = 1_500_000;
    localparam logic [23:0] DKEY = 24'h5A3C81;
    localparam logic [3:0] A_TIME = 4'h0, A_DATE = 4'h4, A_SUB = 4'h8, A_STAT = 4'hC;

    logic        pclk = 1'b0, rtc_clk = 1'b0;
    logic        sys_rst_n = 1'b0, por_n = 1'b0;
    logic        bypass = 1'b0, lowpwr = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [3:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic [23:0] n;
    logic [15:0] live_ss;
    logic [23:0] live_tm, live_dt;

    int checks = 0, fails = 0;
    bit done = 0;

    always #(PCLK_PERIOD/2) pclk = ~pclk;
    always #(RTC_HALF) rtc_clk = ~rtc_clk;

    always_ff @(posedge rtc_clk or negedge por_n) begin
        if (!por_n) n <= 24'h000100;
        else        n <= n + 24'd1;
    end
    assign live_tm = n;
    assign live_dt = n ^ DKEY;
    assign live_ss = n[15:0] + 16'h0100;

    cal_shadow_sync uut (
        .pclk(pclk), .sys_rst_n(sys_rst_n), .rtc_clk(rtc_clk), .por_n(por_n),
        .live_ss(live_ss), .live_tm(live_tm), .live_dt(live_dt),
        .bypass(bypass), .lowpwr(lowpwr), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .prdata(prdata), .pready(pready)
    );

    task automatic check(input string tag, input bit ok, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apb_read(input logic [3:0] a, output logic [31:0] d, output int w, output logic [23:0] n_at);
        @(negedge pclk); psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge pclk); penable = 1; w = 0;
        #1;
        while (!pready) begin @(negedge pclk); w++; #1; end
        d = prdata; n_at = n;
        @(negedge pclk); psel = 0; penable = 0;
    endtask

    task automatic apb_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge pclk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge pclk); penable = 1;
        #1;
        while (!pready) begin @(negedge pclk); #1; end
        @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic wait_flag(input string tag);
        logic [31:0] d; int w; logic [23:0] na; bit seen = 0;
        for (int i = 0; i < 30 && !seen; i++) begin
            apb_read(A_STAT, d, w, na);
            seen = d[0];
        end
        check(tag, seen, {31'd0, seen}, 32'd1);
    endtask

    task automatic read_cal_coherent(input string tag, output logic [23:0] tm);
        logic [31:0] t, s, dt; int w; logic [23:0] na, nb;
        apb_read(A_TIME, t, w, na);
        apb_read(A_SUB, s, w, nb);
        apb_read(A_DATE, dt, w, nb);
        tm = t[23:0];
        check({tag, " date"}, dt[23:0] == (tm ^ DKEY), dt, {8'd0, tm ^ DKEY});
        check({tag, " subsec"}, s[15:0] == tm[15:0] + 16'h0100, s, {16'd0, tm[15:0] + 16'h0100});
        check({tag, " fresh"}, (na - tm) <= 24'd3, {8'd0, tm}, {8'd0, na});
    endtask

    task automatic t_reset();
        logic [31:0] d; int w; logic [23:0] na;
        repeat (3) @(negedge pclk);
        por_n = 1; sys_rst_n = 1;
        apb_read(A_STAT, d, w, na); check("R1 flag after reset", d == 0, d, 0);
        apb_read(A_TIME, d, w, na); check("R1 time after reset", d == 0, d, 0);
        apb_read(A_DATE, d, w, na); check("R1 date after reset", d == 0, d, 0);
        #1000;
        apb_read(A_STAT, d, w, na); check("R6 no copy in low power", d == 0, d, 0);
    endtask

    task automatic t_first_copy();
        logic [23:0] tm;
        @(negedge pclk); lowpwr = 0;
        wait_flag("R2 flag sets after copy");
        read_cal_coherent("R2", tm);
    endtask

    task automatic t_clear_and_lp();
        logic [31:0] d; int w; logic [23:0] na, tm0;
        apb_write(A_STAT, 32'h1);
        apb_read(A_STAT, d, w, na); check("R3 write 1 keeps set flag", d == 1, d, 1);
        @(negedge pclk); lowpwr = 1;
        repeat (4) @(negedge pclk);
        apb_read(A_TIME, d, w, na); tm0 = d[23:0];
        apb_read(A_DATE, d, w, na);
        apb_write(A_STAT, 32'h0);
        apb_read(A_STAT, d, w, na); check("R3 write 0 clears flag", d == 0, d, 0);
        apb_write(A_STAT, 32'hFFFF_FFFF);
        apb_read(A_STAT, d, w, na); check("R3 write 1 has no effect", d == 0, d, 0);
        #1000;
        apb_read(A_STAT, d, w, na); check("R6 flag stays clear in low power", d == 0, d, 0);
        apb_read(A_TIME, d, w, na); check("R6 time shadow held", d[23:0] == tm0, d, {8'd0, tm0});
        apb_read(A_DATE, d, w, na);
        @(negedge pclk); lowpwr = 0;
        wait_flag("R6 flag sets after wakeup");
    endtask

    task automatic t_lock(input logic [3:0] arm_addr, input string tag);
        logic [31:0] d; int w; logic [23:0] na, tm, tm2;
        apb_read(arm_addr, d, w, na);
        tm = (arm_addr == A_TIME) ? d[23:0] : 24'd0;
        apb_write(A_STAT, 32'h0);
        #1000;
        apb_read(A_STAT, d, w, na); check({tag, " no copy while locked"}, d == 0, d, 0);
        if (arm_addr == A_SUB) begin
            apb_read(A_DATE, d, w, na);
            tm = d[23:0] ^ DKEY;
            check({tag, " date stale under lock"}, (na - tm) >= 24'd4, {8'd0, tm}, {8'd0, na});
        end else begin
            apb_read(A_DATE, d, w, na);
            check({tag, " date matches time"}, d[23:0] == (tm ^ DKEY), d, {8'd0, tm ^ DKEY});
            check({tag, " counters moved on"}, (na - tm) >= 24'd4, {8'd0, tm}, {8'd0, na});
        end
        wait_flag("R5 copy resumes after date read");
        read_cal_coherent("R5", tm2);
        check("R5 newer values", tm2 != tm, {8'd0, tm2}, {8'd0, tm});
    endtask

    task automatic t_bypass();
        logic [31:0] d; int w; logic [23:0] na;
        @(negedge pclk); bypass = 1;
        apb_read(A_TIME, d, w, na);
        check("R7 live time", d[23:0] == na, d, {8'd0, na});
        check("R8 one wait on bypass time", w == 1, w, 1);
        apb_read(A_DATE, d, w, na);
        check("R7 live date", d[23:0] == (na ^ DKEY), d, {8'd0, na ^ DKEY});
        check("R8 one wait on bypass date", w == 1, w, 1);
        apb_read(A_SUB, d, w, na);
        check("R7 live subsec", d[15:0] == na[15:0] + 16'h0100, d, {16'd0, na[15:0] + 16'h0100});
        apb_read(A_STAT, d, w, na);
        check("R8 status no wait in bypass", w == 0, w, 0);
        apb_read(A_TIME, d, w, na);
        @(negedge pclk); bypass = 0;
        apb_write(A_STAT, 32'h0);
        wait_flag("R7 bypass read did not lock");
        apb_read(A_TIME, d, w, na);
        check("R8 shadow read no wait", w == 0, w, 0);
        apb_read(A_DATE, d, w, na);
    endtask

    task automatic t_sys_reset();
        logic [31:0] d; int w; logic [23:0] na, tm;
        @(negedge pclk); lowpwr = 1; sys_rst_n = 0;
        repeat (5) @(negedge pclk);
        sys_rst_n = 1;
        apb_read(A_STAT, d, w, na); check("R1 flag after system reset", d == 0, d, 0);
        apb_read(A_SUB, d, w, na);  check("R1 subsec after system reset", d == 0, d, 0);
        apb_read(A_DATE, d, w, na);
        @(negedge pclk); lowpwr = 0;
        wait_flag("R2 flag after system reset");
        read_cal_coherent("R2 after system reset", tm);
    endtask

    initial begin
        t_reset();
        t_first_copy();
        t_clear_and_lp();
        t_lock(A_TIME, "R4 time");
        t_lock(A_SUB, "R4 subsec");
        t_bypass();
        t_sys_reset();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(WDOG_NS);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule